// File: doc/BRIEF.md
# Flash Block Lock Protection Controller

This block guards a sixteen-block nonvolatile array with two levels of write protection. Each block has its own lock bit. A set lock bit refuses both erase and byte-write requests aimed at that block. Above these sits a single master lock bit. While the master bit is set, no command may change the per-block bits.

The controller takes one decoded request per strobe: a command code and a block index. It answers one cycle later with a one-cycle grant or a one-cycle reject. Lock-bit commands are carried out by the controller itself. Erase and byte-write are only authorised here; the array work belongs to a neighbouring block.

Every granted operation holds a busy indication for a fixed number of cycles, the same way for lock configuration as for erase and write. A rejected erase or write, and a rejected lock command, raises a sticky error flag for the status register. The flag stays up until the clear-status input is pulsed.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), lock_bits equals LOCK_INIT and master_lock equals MASTER_INIT. grant, reject, err_erase, err_write and busy are all 0.
- R2: Erase (cmd 4) and byte write (cmd 5) are granted when the target block's lock bit is 0. When that bit is 1 they are rejected: erase sets err_erase, write sets err_write, and lock state is unchanged.
- R3: Set-block-lock (cmd 1) with master_lock clear is granted and sets only lock_bits[blk]. With master_lock set it is rejected, sets err_write, and leaves lock_bits unchanged.
- R4: Clear-block-locks (cmd 3) with master_lock clear is granted and clears all sixteen lock bits in one operation. With master_lock set it is rejected, sets err_erase, and leaves lock_bits unchanged.
- R5: Set-master-lock (cmd 2) is granted and sets master_lock. No command ever clears master_lock; only reset does.
- R6: grant and reject are never high together. For a strobe at clock edge t, exactly one of them is high in the cycle after edge t, for that cycle only. Neither is ever high without a strobe.
- R7: After every grant, busy is high for exactly BUSY_CYCLES cycles. A request strobed while busy is high is rejected without setting any error flag and without changing lock state.
- R8: err_erase and err_write stay set until clr_status is sampled high. When clr_status and a new flag-setting rejection fall on the same edge, the new flag is left set and the other flag is cleared.
- R9: Command codes 0, 6 and 7 are rejected without setting any flag and without changing lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, evaluated at the edge it is high |
| req_cmd | input | 3 | Command code (1 set block lock, 2 set master, 3 clear block locks, 4 erase, 5 write) |
| req_blk | input | 4 | Target block index |
| clr_status | input | 1 | Clears both error flags |
| grant | output | 1 | One-cycle acceptance pulse |
| reject | output | 1 | One-cycle refusal pulse |
| busy | output | 1 | Operation in progress |
| err_erase | output | 1 | Sticky erase/clear-lock error |
| err_write | output | 1 | Sticky write/set-lock error |
| lock_bits | output | 16 | Current per-block lock bits |
| master_lock | output | 1 | Current master lock bit |

## Verification
Two functions can act on the same clock edge: a clr_status pulse, and a rejection that raises an error flag. The bench first raises err_write with a write to a locked block. It then strobes an erase to a locked block with clr_status high on that same edge. The expected result is err_erase set and err_write cleared. The second collision is a new strobe on the first cycle of busy. It must come back as a reject, with the flags and lock_bits unchanged.

// File: rtl/flash_lock_pkg.sv
// Package: shared command encoding for the lock-protection controller.
// Assumes the command field is decoded upstream into these 3-bit codes.
package flash_lock_pkg;
    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_SET_BLOCK  = 3'd1,
        CMD_SET_MASTER = 3'd2,
        CMD_CLR_BLOCKS = 3'd3,
        CMD_ERASE      = 3'd4,
        CMD_WRITE      = 3'd5
    } lock_cmd_e;
endpackage

// File: rtl/flash_lock_policy.sv
// Module: flash_lock_policy
// Purely combinational decision for one request: accept or refuse, which
// error flag to raise, and which lock update to perform.
// Assumes NUM_BLOCKS is a power of two so every index is in range.
module flash_lock_policy
    import flash_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
    input  logic                  valid,
    input  logic [2:0]            cmd,
    input  logic [IDX_W-1:0]      blk,
    input  logic                  busy,
    input  logic [NUM_BLOCKS-1:0] lock_q,
    input  logic                  master_q,
    output logic                  accept,
    output logic                  refuse,
    output logic                  flag_erase,
    output logic                  flag_write,
    output logic                  do_set_blk,
    output logic                  do_set_master,
    output logic                  do_clear
);
    lock_cmd_e cmd_e;
    assign cmd_e = lock_cmd_e'(cmd);

    // Evaluate the request against busy state, master bit and block bit.
    always_comb begin
        accept        = 1'b0;
        refuse        = 1'b0;
        flag_erase    = 1'b0;
        flag_write    = 1'b0;
        do_set_blk    = 1'b0;
        do_set_master = 1'b0;
        do_clear      = 1'b0;
        if (valid) begin
            if (busy) begin
                refuse = 1'b1;
            end else begin
                case (cmd_e)
                    CMD_SET_BLOCK: begin
                        if (master_q) begin
                            refuse     = 1'b1;
                            flag_write = 1'b1;
                        end else begin
                            accept     = 1'b1;
                            do_set_blk = 1'b1;
                        end
                    end
                    CMD_SET_MASTER: begin
                        accept        = 1'b1;
                        do_set_master = 1'b1;
                    end
                    CMD_CLR_BLOCKS: begin
                        if (master_q) begin
                            refuse     = 1'b1;
                            flag_erase = 1'b1;
                        end else begin
                            accept   = 1'b1;
                            do_clear = 1'b1;
                        end
                    end
                    CMD_ERASE: begin
                        if (lock_q[blk]) begin
                            refuse     = 1'b1;
                            flag_erase = 1'b1;
                        end else begin
                            accept = 1'b1;
                        end
                    end
                    CMD_WRITE: begin
                        if (lock_q[blk]) begin
                            refuse     = 1'b1;
                            flag_write = 1'b1;
                        end else begin
                            accept = 1'b1;
                        end
                    end
                    default: refuse = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_lock_bits.sv
// Module: flash_lock_bits
// Holds the per-block lock bits and the master lock bit.
// Assumes do_set_blk and do_clear are never both high (policy guarantees).
module flash_lock_bits #(
    parameter int                  NUM_BLOCKS  = 16,
    parameter logic [NUM_BLOCKS-1:0] LOCK_INIT = '0,
    parameter logic                MASTER_INIT = 1'b0,
    localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  do_set_blk,
    input  logic                  do_set_master,
    input  logic                  do_clear,
    input  logic [IDX_W-1:0]      blk,
    output logic [NUM_BLOCKS-1:0] lock_q,
    output logic                  master_q
);
    // Update block lock bits: clear all, or set the addressed one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= LOCK_INIT;
        end else if (do_clear) begin
            lock_q <= '0;
        end else if (do_set_blk) begin
            lock_q[blk] <= 1'b1;
        end
    end

    // Master bit: only set here, only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= MASTER_INIT;
        end else if (do_set_master) begin
            master_q <= 1'b1;
        end
    end

    // R5: master bit never falls outside reset
    p_master_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        master_q |=> master_q);

    // R3/R4: with master set, block bits cannot move
    p_blocks_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        master_q |=> $stable(lock_q));
endmodule

// File: rtl/flash_lock_status.sv
// Module: flash_lock_status
// Sticky error flags and the busy timer started by each grant.
// Assumes grants never arrive while busy (policy refuses them).
module flash_lock_status #(
    parameter int BUSY_CYCLES = 4,
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic set_erase,
    input  logic set_write,
    input  logic clr_status,
    output logic busy,
    output logic err_erase,
    output logic err_write
);
    logic [CNT_W-1:0] cnt_q;

    // Busy timer: load on grant, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // Error flags: clear first, then a new error overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_erase <= 1'b0;
            err_write <= 1'b0;
        end else begin
            if (clr_status) begin
                err_erase <= 1'b0;
                err_write <= 1'b0;
            end
            if (set_erase) err_erase <= 1'b1;
            if (set_write) err_write <= 1'b1;
        end
    end

    // R8: flags persist without a clear
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_erase && !clr_status) |=> err_erase);

    // R8: a new error on a clear cycle still lands
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_write && clr_status) |=> err_write);

    // R7: a grant always produces busy next cycle
    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/flash_lock_ctrl.sv
// Module: flash_lock_ctrl (top)
// Two-level lock protection for a block array: per-block bits gate erase
// and write; a master bit gates changes to the per-block bits.
// Assumes one request per strobe and registered one-cycle responses.
module flash_lock_ctrl
    import flash_lock_pkg::*;
#(
    parameter int                    NUM_BLOCKS  = 16,
    parameter logic [NUM_BLOCKS-1:0] LOCK_INIT   = '0,
    parameter logic                  MASTER_INIT = 1'b0,
    parameter int                    BUSY_CYCLES = 4,
    localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_cmd,
    input  logic [IDX_W-1:0]      req_blk,
    input  logic                  clr_status,
    output logic                  grant,
    output logic                  reject,
    output logic                  busy,
    output logic                  err_erase,
    output logic                  err_write,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic                  master_lock
);
    logic accept, refuse, flag_erase, flag_write;
    logic do_set_blk, do_set_master, do_clear;

    flash_lock_policy #(.NUM_BLOCKS(NUM_BLOCKS)) u_policy (
        .valid(req_valid), .cmd(req_cmd), .blk(req_blk), .busy(busy),
        .lock_q(lock_bits), .master_q(master_lock),
        .accept(accept), .refuse(refuse),
        .flag_erase(flag_erase), .flag_write(flag_write),
        .do_set_blk(do_set_blk), .do_set_master(do_set_master),
        .do_clear(do_clear)
    );

    flash_lock_bits #(
        .NUM_BLOCKS(NUM_BLOCKS), .LOCK_INIT(LOCK_INIT), .MASTER_INIT(MASTER_INIT)
    ) u_bits (
        .clk(clk), .rst_n(rst_n),
        .do_set_blk(do_set_blk), .do_set_master(do_set_master),
        .do_clear(do_clear), .blk(req_blk),
        .lock_q(lock_bits), .master_q(master_lock)
    );

    flash_lock_status #(.BUSY_CYCLES(BUSY_CYCLES)) u_status (
        .clk(clk), .rst_n(rst_n), .start(accept),
        .set_erase(flag_erase), .set_write(flag_write),
        .clr_status(clr_status),
        .busy(busy), .err_erase(err_erase), .err_write(err_write)
    );

    // Register the response pulses one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant  <= 1'b0;
            reject <= 1'b0;
        end else begin
            grant  <= accept;
            reject <= refuse;
        end
    end

    // R6: responses exclusive
    p_resp_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject));

    // R6: no response without a strobe
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(grant || reject));

    // R2: erase to a locked idle block is refused and flagged
    p_locked_erase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_cmd == CMD_ERASE && lock_bits[req_blk])
        |=> (reject && err_erase));

    // R7: strobe while busy is refused
    p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> (reject && $stable(lock_bits)));
endmodule

// File: tb/flash_lock_ctrl_bench.sv
`timescale 1ns/1ps
module flash_lock_ctrl_bench;
    localparam int NB = 16;
    localparam int BC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [3:0] req_blk = 4'd0;
    logic clr_status = 1'b0;
    logic grant, reject, busy, err_erase, err_write, master_lock;
    logic [NB-1:0] lock_bits;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [NB-1:0] m_lock;
    logic m_master, m_ee, m_we;

    flash_lock_ctrl #(.NUM_BLOCKS(NB), .BUSY_CYCLES(BC)) u_flash_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_blk(req_blk), .clr_status(clr_status), .grant(grant),
        .reject(reject), .busy(busy), .err_erase(err_erase),
        .err_write(err_write), .lock_bits(lock_bits), .master_lock(master_lock)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of the requirements: expected grant and model update.
    function automatic logic model(input logic [2:0] c, input int b, input logic clr);
        logic g;
        g = 1'b0;
        if (clr) begin m_ee = 1'b0; m_we = 1'b0; end
        case (c)
            3'd1: if (m_master) m_we = 1'b1; else begin g = 1'b1; m_lock[b] = 1'b1; end
            3'd2: begin g = 1'b1; m_master = 1'b1; end
            3'd3: if (m_master) m_ee = 1'b1; else begin g = 1'b1; m_lock = '0; end
            3'd4: if (m_lock[b]) m_ee = 1'b1; else g = 1'b1;
            3'd5: if (m_lock[b]) m_we = 1'b1; else g = 1'b1;
            default: g = 1'b0;
        endcase
        return g;
    endfunction

    // Issue one request with the block idle and check the whole response.
    task automatic issue(input logic [2:0] c, input int b, input logic clr, input string tag);
        logic g, r, eg;
        int bcnt;
        eg = model(c, b, clr);
        @(negedge clk);
        req_cmd = c; req_blk = 4'(b); req_valid = 1'b1; clr_status = clr;
        @(negedge clk);
        req_valid = 1'b0; clr_status = 1'b0;
        g = grant; r = reject;
        chk({tag, " grant"}, 32'(g), 32'(eg));
        chk({tag, " R6 one response"}, 32'(g ^ r), 32'd1);
        chk({tag, " lock_bits"}, 32'(lock_bits), 32'(m_lock));
        chk({tag, " master"}, 32'(master_lock), 32'(m_master));
        chk({tag, " R8 flags"}, {30'd0, err_erase, err_write}, {30'd0, m_ee, m_we});
        bcnt = 0;
        while (busy && bcnt < 100) begin bcnt++; @(negedge clk); end
        chk({tag, " R7 busy length"}, 32'(bcnt), eg ? BC : 0);
        if (bcnt == 0) @(negedge clk);
        chk({tag, " R6 pulse ends"}, {30'd0, grant, reject}, 32'd0);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_lock = '0; m_master = 1'b0; m_ee = 1'b0; m_we = 1'b0;
        chk("R1 lock_bits", 32'(lock_bits), 32'd0);
        chk("R1 master", 32'(master_lock), 32'd0);
        chk("R1 outputs", {27'd0, grant, reject, busy, err_erase, err_write}, 32'd0);
    endtask

    initial begin
        do_reset();
        // R2: all unlocked, every block erase and write granted
        for (int b = 0; b < NB; b++) begin
            issue(3'd4, b, 1'b0, "R2 erase open");
            issue(3'd5, b, 1'b0, "R2 write open");
        end
        // R3: lock the even blocks one at a time
        for (int b = 0; b < NB; b += 2) issue(3'd1, b, 1'b0, "R3 set block");
        // R2: sweep against the mixed pattern
        for (int b = 0; b < NB; b++) begin
            issue(3'd4, b, 1'b0, "R2 erase mixed");
            issue(3'd5, b, 1'b0, "R2 write mixed");
        end
        // R8: clear status alone
        @(negedge clk); clr_status = 1'b1; @(negedge clk); clr_status = 1'b0;
        m_ee = 1'b0; m_we = 1'b0;
        chk("R8 clear", {30'd0, err_erase, err_write}, 32'd0);
        // R9: undefined codes
        issue(3'd0, 1, 1'b0, "R9 code0");
        issue(3'd6, 3, 1'b0, "R9 code6");
        issue(3'd7, 5, 1'b0, "R9 code7");
        // R7: strobe on the first busy cycle
        void'(model(3'd4, 1, 1'b0));
        @(negedge clk); req_cmd = 3'd4; req_blk = 4'd1; req_valid = 1'b1;
        @(negedge clk); req_cmd = 3'd1; req_blk = 4'd1;
        chk("R7 first grant", 32'(grant), 32'd1);
        @(negedge clk); req_valid = 1'b0;
        chk("R7 busy reject", {30'd0, grant, reject}, 32'd1);
        chk("R7 busy no flag", {30'd0, err_erase, err_write}, 32'd0);
        chk("R7 busy no lock change", 32'(lock_bits), 32'(m_lock));
        while (busy) @(negedge clk);
        // R8: collision of clear-status and a new error
        issue(3'd5, 0, 1'b0, "R8 raise write error");
        issue(3'd4, 0, 1'b1, "R8 clear with new erase error");
        // R4: clear all blocks with master clear
        issue(3'd3, 0, 1'b0, "R4 clear blocks");
        issue(3'd1, 3, 1'b0, "R3 set block 3");
        // R5: set master, then lock commands refused
        issue(3'd2, 0, 1'b0, "R5 set master");
        issue(3'd1, 5, 1'b0, "R3 set under master");
        issue(3'd3, 0, 1'b0, "R4 clear under master");
        issue(3'd4, 4, 1'b0, "R2 erase open under master");
        issue(3'd4, 3, 1'b0, "R2 erase locked under master");
        issue(3'd2, 0, 1'b0, "R5 set master again");
        chk("R5 master still set", 32'(master_lock), 32'd1);
        do_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule